// File: doc/BRIEF.md
# Masked-Write GPIO Register Bank

This block holds the output-enable and output-value state for several banks of general-purpose pins and turns it into pad drive signals. Software reaches it through a plain register write port: an address, a data word and a one-cycle write strobe. Every write to a pin register carries its own bit mask in the upper half of the data word. Only the pins named by the mask change, so one pin can be flipped without first reading the register back.

The stored pin values do not reach the pads unmodified. Each bank has a debug-select bit, and when that bit is set the bank's outputs follow an internal debug bus instead. If the bit is clear, an automatic transmit/receive overlay comes from outside as a per-pin mask and value pair. Every pin the overlay selects takes the overlay value, and the other pins keep the stored value. The output-enable seen by the pads always comes straight from the output-enable register.

The write port and the overlay inputs are plain control signals. They have no valid/ready handshake and cannot apply back-pressure: a write is accepted in the cycle its strobe is high.

Top module: `gpio_mask_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pad_oe` and all stored registers are zero. With `atr_mask` at zero, `pad_out` is zero as well.
- R2: A write to address 5+b updates the output-enable register of bank b. Data bits 31:16 are the mask and bits 15:0 are the value. Each pin whose mask bit is 1 takes its value bit, and every other pin keeps its old state.
- R3: A write to address 9+b updates the output-value register of bank b, using the same mask and value split as R2.
- R4: A write whose mask half is all zeros leaves the addressed register unchanged.
- R5: A write becomes visible at the outputs after the rising clock edge that samples the strobe. The following have no effect on any register: a cycle with the strobe low, and a write to any address other than 5–12 and 14.
- R6: `pad_oe` equals the output-enable registers at all times. The debug selects and the overlay have no effect on it.
- R7: A write to address 14 loads the debug-select register from data bits 3:0, with bit b for bank b. While bit b is set, the pins of bank b drive `dbg_val` for that bank, whatever the overlay or output-value register holds.
- R8: While the debug bit of bank b is clear, each pin with its `atr_mask` bit set drives its `atr_val` bit. Each pin with its mask bit clear drives the output-value register bit.
- R9: Bank b occupies bits 16b+15 down to 16b of every 64-bit pin bus (`pad_out`, `pad_oe`, `dbg_val`, `atr_mask`, `atr_val`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 7 | Register address |
| wr_data | input | 32 | Write data: mask in 31:16, value in 15:0 |
| dbg_val | input | 64 | Debug pin values, 16 per bank |
| atr_mask | input | 64 | Overlay select per pin |
| atr_val | input | 64 | Overlay value per pin |
| pad_out | output | 64 | Pin drive value, 16 per bank |
| pad_oe | output | 64 | Pin output enable, 16 per bank |

## Verification
The hardest condition to reach is a pin where all three value sources disagree while the priority between them is being checked. That needs a nonzero stored value, a debug bus pattern different from it, and an overlay value different from both. The bench first builds distinct stored patterns in several banks with partial-mask writes. It then drives distinct constants on `dbg_val` and `atr_val`. It turns the debug select on and off while the overlay mask covers some pins and not others, and it confirms each time that `pad_oe` did not move.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W      = 7;
  localparam int OE_BASE     = 5;   // bank b output-enable at OE_BASE + b
  localparam int VAL_BASE    = 9;   // bank b output-value  at VAL_BASE + b
  localparam int DBG_SEL_ADR = 14;  // per-bank debug select
endpackage

// File: rtl/gpio_mask_reg.sv
// One bank-wide register with a per-bit masked update.
module gpio_mask_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic [W-1:0] upd_mask,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (hit) q <= (q & ~upd_mask) | (upd_val & upd_mask);
  end
endmodule

// File: rtl/gpio_pin_mux.sv
// Pin value priority: debug, then overlay, then stored value.
module gpio_pin_mux #(
  parameter int W = 16
) (
  input  logic         dbg_on,
  input  logic [W-1:0] dbg_bits,
  input  logic [W-1:0] ovl_mask,
  input  logic [W-1:0] ovl_bits,
  input  logic [W-1:0] reg_bits,
  output logic [W-1:0] pin_bits
);
  logic [W-1:0] merged;
  always_comb begin
    merged   = (reg_bits & ~ovl_mask) | (ovl_bits & ovl_mask);
    pin_bits = dbg_on ? dbg_bits : merged;
  end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_bank_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [2*BANK_W-1:0]     wr_data,
  input  logic [NBANK*BANK_W-1:0] dbg_val,
  input  logic [NBANK*BANK_W-1:0] atr_mask,
  input  logic [NBANK*BANK_W-1:0] atr_val,
  output logic [NBANK*BANK_W-1:0] pad_out,
  output logic [NBANK*BANK_W-1:0] pad_oe
);
  localparam int PINS = NBANK * BANK_W;

  logic [BANK_W-1:0] wmask, wval;
  logic [NBANK-1:0]  dbg_sel_q;
  logic [PINS-1:0]   val_q;

  assign wmask = wr_data[2*BANK_W-1:BANK_W];
  assign wval  = wr_data[BANK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_sel_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(DBG_SEL_ADR)) dbg_sel_q <= wr_data[NBANK-1:0];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_oe, hit_val;
    assign hit_oe  = wr_en && (wr_addr == ADDR_W'(OE_BASE + b));
    assign hit_val = wr_en && (wr_addr == ADDR_W'(VAL_BASE + b));

    gpio_mask_reg #(.W(BANK_W)) u_oe (
      .clk(clk), .rst_n(rst_n), .hit(hit_oe),
      .upd_mask(wmask), .upd_val(wval),
      .q(pad_oe[b*BANK_W +: BANK_W])
    );

    gpio_mask_reg #(.W(BANK_W)) u_val (
      .clk(clk), .rst_n(rst_n), .hit(hit_val),
      .upd_mask(wmask), .upd_val(wval),
      .q(val_q[b*BANK_W +: BANK_W])
    );

    gpio_pin_mux #(.W(BANK_W)) u_mux (
      .dbg_on(dbg_sel_q[b]),
      .dbg_bits(dbg_val[b*BANK_W +: BANK_W]),
      .ovl_mask(atr_mask[b*BANK_W +: BANK_W]),
      .ovl_bits(atr_val[b*BANK_W +: BANK_W]),
      .reg_bits(val_q[b*BANK_W +: BANK_W]),
      .pin_bits(pad_out[b*BANK_W +: BANK_W])
    );
  end
endmodule

// File: rtl/gpio_mask_bank_chk.sv
module gpio_mask_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [2*BANK_W-1:0]     wr_data,
  input logic [NBANK*BANK_W-1:0] dbg_val,
  input logic [NBANK*BANK_W-1:0] atr_mask,
  input logic [NBANK*BANK_W-1:0] atr_val,
  input logic [NBANK*BANK_W-1:0] pad_out,
  input logic [NBANK*BANK_W-1:0] pad_oe,
  input logic [NBANK-1:0]        dbg_sel
);
  // R1
  p_oe_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0));

  // R5, R6: pad_oe moves only after an output-enable write
  p_oe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr >= ADDR_W'(OE_BASE) && wr_addr < ADDR_W'(OE_BASE + NBANK))
    |=> $stable(pad_oe));

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    // R2, R4: unmasked enable bits keep their state
    p_oe_unmasked_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(OE_BASE + b)) |=>
      (((pad_oe[b*BANK_W +: BANK_W] ^ $past(pad_oe[b*BANK_W +: BANK_W]))
        & ~$past(wr_data[2*BANK_W-1:BANK_W])) == '0));

    // R2: masked enable bits take the written value
    p_oe_masked_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(OE_BASE + b)) |=>
      ((pad_oe[b*BANK_W +: BANK_W] & $past(wr_data[2*BANK_W-1:BANK_W])) ==
       ($past(wr_data[BANK_W-1:0]) & $past(wr_data[2*BANK_W-1:BANK_W]))));

    // R7: debug select wins
    p_dbg_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_sel[b] |-> (pad_out[b*BANK_W +: BANK_W] == dbg_val[b*BANK_W +: BANK_W]));

    // R8: overlay pins follow the overlay when debug is off
    p_atr_overlay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_sel[b] |-> (((pad_out[b*BANK_W +: BANK_W] ^ atr_val[b*BANK_W +: BANK_W])
                        & atr_mask[b*BANK_W +: BANK_W]) == '0));
  end
endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(.NBANK(NBANK), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .dbg_val(dbg_val), .atr_mask(atr_mask), .atr_val(atr_val),
  .pad_out(pad_out), .pad_oe(pad_oe), .dbg_sel(dbg_sel_q)
);

// File: tb/tb_gpio_mask_bank.sv
module tb_gpio_mask_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] dbg_val = '0;
  logic [63:0] atr_mask = '0;
  logic [63:0] atr_val = '0;
  logic [63:0] pad_out, pad_oe;

  int nvec = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  gpio_mask_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_val(dbg_val), .atr_mask(atr_mask), .atr_val(atr_val),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct packed {
    logic [6:0]  adr;
    logic [31:0] dat;
    logic [1:0]  bank;
    logic [15:0] exp_oe;
    logic [15:0] exp_out;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{7'd5,  32'hFFFF_A5A5, 2'd0, 16'hA5A5, 16'h0000, 4'd2}, // R2 full mask
    '{7'd5,  32'h00F0_0F0F, 2'd0, 16'hA505, 16'h0000, 4'd2}, // R2 partial mask
    '{7'd9,  32'h0000_FFFF, 2'd0, 16'hA505, 16'h0000, 4'd4}, // R4 zero mask
    '{7'd9,  32'h0F0F_1234, 2'd0, 16'hA505, 16'h0204, 4'd3}, // R3 partial
    '{7'd10, 32'hFFFF_BEEF, 2'd1, 16'h0000, 16'hBEEF, 4'd3}, // R3 bank1
    '{7'd8,  32'hFFFF_C3C3, 2'd3, 16'hC3C3, 16'h0000, 4'd2}, // R2 bank3
    '{7'd13, 32'hFFFF_FFFF, 2'd3, 16'hC3C3, 16'h0000, 4'd5}, // R5 unrelated addr
    '{7'd12, 32'h8001_FFFF, 2'd3, 16'hC3C3, 16'h8001, 4'd3}, // R3 bank3
    '{7'd7,  32'h0001_0001, 2'd2, 16'h0001, 16'h0000, 4'd2}, // R2 bank2
    '{7'd9,  32'hFFFF_0000, 2'd0, 16'hA505, 16'h0000, 4'd3}  // R3 clear all
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pad_oe, 64'h0);
    check("R1 out in reset", pad_out, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe after release", pad_oe, 64'h0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].adr, VEC[i].dat);
      check($sformatf("R%0d vec%0d oe", VEC[i].req, i), 64'(pad_oe[VEC[i].bank*16 +: 16]), 64'(VEC[i].exp_oe));
      check($sformatf("R%0d vec%0d out", VEC[i].req, i), 64'(pad_out[VEC[i].bank*16 +: 16]), 64'(VEC[i].exp_out));
    end

    // R9 packing of the whole bus
    check("R9 oe bus", pad_oe, 64'hC3C3_0001_0000_A505);
    check("R9 out bus", pad_out, 64'h8001_0000_BEEF_0000);

    // R5 strobe low: address and data present but no write
    @(negedge clk);
    wr_addr = 7'd5; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_addr = '0; wr_data = '0;
    check("R5 strobe low", pad_oe, 64'hC3C3_0001_0000_A505);

    // R7 debug select on bank0, overlay also covering bank0
    dbg_val  = 64'h1111_2222_3333_4444;
    atr_mask = 64'h0000_0000_0000_FFFF;
    atr_val  = 64'h0000_0000_0000_AAAA;
    do_write(7'd14, 32'hFFFF_0001);
    check("R7 debug wins", pad_out, 64'h8001_0000_BEEF_4444);
    check("R6 oe under debug", pad_oe, 64'hC3C3_0001_0000_A505);

    // R8 debug off, partial overlay on banks 0 and 1
    atr_mask = 64'h0000_0000_F000_00FF;
    atr_val  = 64'h0000_0000_5555_AAAA;
    do_write(7'd14, 32'h0000_0000);
    check("R8 overlay", pad_out, 64'h8001_0000_5EEF_00AA);
    check("R6 oe under overlay", pad_oe, 64'hC3C3_0001_0000_A505);

    // R7 debug on bank3 only
    do_write(7'd14, 32'h0000_0008);
    check("R7 debug bank3", pad_out, 64'h1111_0000_5EEF_00AA);

    // R1 reset again mid-run
    atr_mask = '0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 oe re-reset", pad_oe, 64'h0);
    check("R1 out re-reset", pad_out, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out after re-release", pad_out, 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule